// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces the programmable periodic interrupt of a real-time clock. A 32.768 kHz tick arrives as a one-cycle enable on the system clock. A free-running 15-bit count of those ticks sets the timing. The interrupt rate is chosen by a 4-bit rate code and gated by a periodic-interrupt enable. Both inputs are taken straight from the clock's control registers.

Each time the period elapses, the block issues two one-cycle pulses. The first is a flag-set pulse toward the status register, carrying the interrupt flag and the periodic flag. The second is an interrupt request. Expiries always fall on multiples of the period on the running count. Changing the rate or the enable therefore never restarts the phase: the next expiry is the first multiple of the new period that lies strictly after the current count.

Top module: `prd_rate_gen`

## Requirements
- R1: After reset, `irq_o` is 0, `flag_set_o` is 0 and the tick count is zero, so the first expiry happens when the count reaches one full period.
- R2: A rate code of 0 stops the generator: no pulses are issued.
- R3: With `pie_en_i` low, no pulses are issued, whatever the rate code.
- R4: For rate codes 3 to 15, the period is 2^(code-1) ticks.
- R5: Rate codes 1 and 2 behave as codes 8 and 9, giving periods of 128 and 256 ticks.
- R6: An expiry occurs on a tick that brings the count to a multiple of the current period. A rate change mid-period does not restart timing: the next pulse comes at the next multiple of the new period.
- R7: On expiry, `irq_o` is 1 and `flag_set_o` is 8'hC0 (bit 7 is the interrupt flag, bit 6 the periodic flag), for exactly one clock cycle. This is the cycle after the clock edge that took the tick. At all other times both outputs are 0.
- R8: The tick count runs whether the generator is stopped or not. After the generator is enabled, the first expiry is aligned to the absolute count, not to the moment of enabling.
- R9: Without a tick no pulse is issued, and the count holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable per 32.768 kHz period |
| rate_sel_i | input | 4 | Rate code; 0 stops, 1 and 2 alias to 8 and 9 |
| pie_en_i | input | 1 | Periodic interrupt enable |
| flag_set_o | output | 8 | Status flag-set pulse, 8'hC0 on expiry |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The assertions assume that the rate code and the enable are steady values sampled on the clock. They also assume that any legal code gives a period of at least four ticks, so two expiries can never fall on adjacent cycles. The stimulus changes the rate code and the enable only between clock edges. It drives the tick both continuously and with gaps. A bench model that counts ticks from reset predicts every pulse from the requirements. The stimulus also switches rates mid-period and enables the generator at arbitrary counts, so that alignment to the absolute count is exercised.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CNT_W    = 15;
  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned IRQF_BIT = 7;
  localparam int unsigned PERF_BIT = 6;
  localparam int unsigned ALIAS_MAX = 2;
  localparam int unsigned ALIAS_ADD = 7;
  typedef logic [CODE_W-1:0] rate_code_t;
  typedef logic [CNT_W-1:0]  tick_cnt_t;
endpackage

// File: rtl/prd_rate_decode.sv
module prd_rate_decode #(
  parameter int unsigned CODE_W    = prd_pkg::CODE_W,
  parameter int unsigned CNT_W     = prd_pkg::CNT_W,
  parameter int unsigned ALIAS_MAX = prd_pkg::ALIAS_MAX,
  parameter int unsigned ALIAS_ADD = prd_pkg::ALIAS_ADD
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              pie_i,
  output logic              run_o,
  output logic [CNT_W-1:0]  mask_o
);
  localparam int unsigned EW = CODE_W + 1;

  logic [EW-1:0] eff_code;
  logic [EW-1:0] shift;

  always_comb begin
    if (code_i <= CODE_W'(ALIAS_MAX)) eff_code = {1'b0, code_i} + EW'(ALIAS_ADD);
    else                              eff_code = {1'b0, code_i};
    shift = eff_code - EW'(1);
  end

  assign run_o = pie_i && (code_i != '0);

  // low (code-1) bits set: expiry when these bits of the count are all ones before the tick
  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign mask_o[g] = (shift > EW'(g));
  end
endmodule

// File: rtl/prd_cycle_cnt.sv
module prd_cycle_cnt #(
  parameter int unsigned CNT_W = prd_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R8
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/prd_expiry.sv
module prd_expiry #(
  parameter int unsigned CNT_W = prd_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o
);
  logic hit_d, hit_q;

  // next count lands on a period multiple
  assign hit_d = tick_i && run_i && ((cnt_i & mask_i) == mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit_d;
  end

  assign hit_o = hit_q;

  AST_HIT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |-> (cnt_i & $past(mask_i)) == '0); // R6
  AST_HIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |=> !hit_q); // R7
endmodule

// File: rtl/prd_rate_gen.sv
module prd_rate_gen #(
  parameter int unsigned CODE_W = prd_pkg::CODE_W,
  parameter int unsigned CNT_W  = prd_pkg::CNT_W,
  parameter int unsigned FLAG_W = prd_pkg::FLAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] rate_sel_i,
  input  logic              pie_en_i,
  output logic [FLAG_W-1:0] flag_set_o,
  output logic              irq_o
);
  logic             run;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt;
  logic             hit;

  prd_rate_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) i_decode (
    .code_i (rate_sel_i),
    .pie_i  (pie_en_i),
    .run_o  (run),
    .mask_o (mask)
  );

  prd_cycle_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt)
  );

  prd_expiry #(.CNT_W(CNT_W)) i_expiry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (run),
    .mask_i (mask),
    .cnt_i  (cnt),
    .hit_o  (hit)
  );

  always_comb begin
    flag_set_o = '0;
    flag_set_o[prd_pkg::IRQF_BIT] = hit;
    flag_set_o[prd_pkg::PERF_BIT] = hit;
  end
  assign irq_o = hit;

  AST_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i)); // R9
  AST_STOP_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(rate_sel_i) != '0); // R2
  AST_STOP_PIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(pie_en_i)); // R3
  AST_PERIOD_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt[1:0] == 2'b00); // R4
endmodule

// File: tb/test_prd_rate_gen.sv
module test_prd_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] rate = 4'd0;
  logic       pie = 1'b0;
  logic [7:0] flags;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int model_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prd_rate_gen i_prd_rate_gen (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rate_sel_i(rate),
    .pie_en_i(pie), .flag_set_o(flags), .irq_o(irq)
  );

  function automatic int period_of(input int code);
    int e;
    e = (code <= 2) ? code + 7 : code;
    return 1 << (e - 1);
  endfunction

  task automatic check(input string req, input bit exp_p);
    logic [7:0] ef;
    ef = exp_p ? 8'hC0 : 8'h00;
    checks++;
    if (irq !== exp_p || flags !== ef) begin
      fails++;
      $display("FAIL %s cnt=%0d irq=%b flags=%h expected irq=%b flags=%h",
               req, model_cnt, irq, flags, exp_p, ef);
    end
  endtask

  // drive one clock with tick value v, then check the pulse
  task automatic step(input string req, input bit v);
    bit en;
    en = pie && (rate != 4'd0);
    tick = v;
    @(posedge clk);
    #1;
    if (v) model_cnt = (model_cnt + 1) % 32768;
    check(req, v && en && (model_cnt % period_of(int'(rate)) == 0));
  endtask

  task automatic run(input string req, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(req, 1'b1);
      for (int j = 0; j < gap; j++) step(req, 1'b0);
    end
  endtask

  task automatic test_reset();
    #1;
    check("R1", 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", 1'b0);
    rate = 4'd3; pie = 1'b1;
    run("R1", 4, 0);  // first expiry at count 4
  endtask

  task automatic test_code_zero();
    rate = 4'd0; pie = 1'b1;
    run("R2", 300, 0);
  endtask

  task automatic test_pie_off();
    rate = 4'd3; pie = 1'b0;
    run("R3", 100, 1);
  endtask

  task automatic test_late_enable();
    rate = 4'd0; pie = 1'b1;
    run("R8", 37, 0);
    rate = 4'd5;
    run("R8", 40, 0);
  endtask

  task automatic test_rates();
    pie = 1'b1;
    for (int c = 3; c <= 15; c++) begin
      rate = 4'(c);
      run("R4", 2 * period_of(c), 0);
    end
  endtask

  task automatic test_alias();
    pie = 1'b1;
    rate = 4'd1; run("R5", 300, 0);
    rate = 4'd2; run("R5", 600, 0);
  endtask

  task automatic test_rate_change();
    pie = 1'b1;
    rate = 4'd4;
    while (model_cnt % 8 != 3) step("R6", 1'b1);
    rate = 4'd6;
    run("R6", 70, 0);
    rate = 4'd3;
    run("R6", 20, 2);
  endtask

  task automatic test_no_tick();
    pie = 1'b1; rate = 4'd3;
    while (model_cnt % 4 != 3) step("R9", 1'b1);
    for (int i = 0; i < 20; i++) step("R9", 1'b0);
    step("R9", 1'b1);  // expiry only once the tick arrives
    run("R7", 40, 3);
  endtask

  initial begin
    test_reset();
    test_code_zero();
    test_pie_off();
    test_late_enable();
    test_rates();
    test_alias();
    test_rate_change();
    test_no_tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule